// File: doc/BRIEF.md
# Byte-Wide EEPROM Page Programming Controller

This block models the write path of a byte-wide parallel EEPROM on a clocked interface. The active-low chip-select, read-strobe and write-strobe inputs are sampled on every clock. A write cycle captures its address when it opens and its data when it closes. Accepted byte loads collect in a page buffer that holds one page. Each accepted load restarts a byte-load window. When the window runs out with no new load, the controller starts a timed programming cycle. At the end of that cycle it copies the page into a behavioural array and pulses a completion flag.

While programming is under way, reads do not return plain stored data. The top bit is the inverse of the top bit of the last byte loaded. The next bit flips after every read. The remaining bits show the current array contents. Software can therefore poll for completion using either bit. All timings are parameters counted in clock cycles: the byte-load window, the programming length and the minimum write-strobe low width.

Top module: `eeprom_pgm_ctrl`

## Requirements
- R1: A write cycle is open only on cycles where ce_ni=0, we_ni=0 and oe_ni=1. A write with oe_ni low never loads a byte. A write cycle during which oe_ni drops before ce_ni or we_ni rises is discarded.
- R2: The address is taken on the first cycle of a write cycle. The data is taken on the last cycle of that write cycle. Later changes of addr_i inside the cycle are ignored.
- R3: A write cycle counts as a byte load only if it lasts at least MIN_WE_LOW sampled clock edges. A shorter one changes neither the array nor busy_o.
- R4: The page address is addr_i[12:6], and the byte index within the page is addr_i[5:0]. While a page is being loaded, a load with a different page address is ignored and does not restart the window.
- R5: busy_o rises LOAD_WIN clock edges after the edge that closes the last accepted load. Each accepted load in the page restarts this count, and the count is held while a write cycle is open.
- R6: busy_o stays high for exactly PROG_CYC cycles. When it falls, every loaded byte is in the array, and done_o is high for exactly the one following cycle.
- R7: While busy_o=1, bit 7 of a read is the inverse of bit 7 of the last accepted load. After programming, the read returns the true byte.
- R8: While busy_o=1, bit 6 of a read is 0 for the first read after programming starts and flips after each completed read.
- R9: data_oe_o=1 exactly when ce_ni=0 and oe_ni=0. Otherwise data_o is 0. Outside programming, a read returns the array byte at addr_i[MEM_AW-1:0], and the array starts cleared.
- R10: Write cycles made while busy_o=1 are ignored and do not open a new page.
- R11: When the same byte index is loaded twice within a page, the later data is what gets programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Read strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data or programming status |
| data_oe_o | output | 1 | Read data bus is driven |
| busy_o | output | 1 | Programming cycle in progress |
| done_o | output | 1 | One-cycle pulse when programming ends |

## Verification
Some rules are checked on every cycle. A quiet bus reads as zero. A write with the read strobe low never loads a byte. Nothing reaches the page buffer during programming. The completion pulse follows the fall of busy and lasts one cycle. The polled top bit stays inverted while busy. The toggle bit flips after each read made during programming.

Other rules depend on a whole sequence and can only be shown by the bench's scenarios. These are the exact window length and its restart, the short-pulse and cross-page rejections, the address and data capture points, and the final array contents after a page with an overwritten byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } seq_state_e;
endpackage

// File: rtl/eep_strobe.sv
// Qualifies write and read strobes; captures address at open, data at close.
module eep_strobe #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int MIN_WE_LOW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_act_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rd_act_o,
  output logic              rd_end_o
);
  localparam int CW = $clog2(MIN_WE_LOW + 1);

  logic          wr_q, rd_q;
  logic [CW-1:0] wcnt_q;

  assign wr_act_o = !ce_ni && !we_ni && oe_ni;
  assign rd_act_o = !ce_ni && !oe_ni;
  // close only via ce/we rising; oe falling aborts the cycle
  assign commit_o = wr_q && !wr_act_o && oe_ni && (wcnt_q >= CW'(MIN_WE_LOW));
  assign rd_end_o = rd_q && !rd_act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      wcnt_q <= '0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      wr_q <= wr_act_o;
      rd_q <= rd_act_o;
      if (wr_act_o) begin
        data_o <= data_i;
        if (!wr_q) begin
          addr_o <= addr_i;
          wcnt_q <= CW'(1);
        end else if (wcnt_q != CW'(MIN_WE_LOW)) begin
          wcnt_q <= wcnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] byte_o [1<<PAGE_W],
  output logic              vld_o  [1<<PAGE_W]
);
  for (genvar g = 0; g < (1 << PAGE_W); g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]  <= 1'b0;
        byte_o[g] <= '0;
      end else if (clr_i) begin
        vld_o[g] <= 1'b0;
      end else if (wr_i && idx_i == PAGE_W'(g)) begin
        vld_o[g]  <= 1'b1;
        byte_o[g] <= data_i;
      end
    end
  end
endmodule

// File: rtl/eep_seq.sv
// Page load window and programming timer.
module eep_seq
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 6,
  parameter int LOAD_WIN = 25000,
  parameter int PROG_CYC = 1250000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  logic                     wr_act_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     msb_i,
  input  logic                     rd_end_i,
  output logic                     load_ok_o,
  output logic                     prog_end_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic                     last_msb_o,
  output logic                     tog_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam int LW = $clog2(LOAD_WIN + 1);
  localparam int PW = $clog2(PROG_CYC + 1);

  seq_state_e    st_q;
  logic [LW-1:0] tmr_q;
  logic [PW-1:0] pcnt_q;
  logic          page_hit;

  assign page_hit   = addr_i[ADDR_W-1:PAGE_W] == page_o;
  assign load_ok_o  = commit_i && (st_q == ST_IDLE || (st_q == ST_LOAD && page_hit));
  assign prog_end_o = st_q == ST_PROG && pcnt_q == PW'(PROG_CYC - 1);
  assign busy_o     = st_q == ST_PROG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      tmr_q      <= '0;
      pcnt_q     <= '0;
      page_o     <= '0;
      last_msb_o <= 1'b0;
      tog_o      <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (load_ok_o) begin
          page_o     <= addr_i[ADDR_W-1:PAGE_W];
          last_msb_o <= msb_i;
          tmr_q      <= '0;
          st_q       <= ST_LOAD;
        end
        ST_LOAD: begin
          if (load_ok_o) begin
            last_msb_o <= msb_i;
            tmr_q      <= '0;
          end else if (!wr_act_i) begin
            if (tmr_q == LW'(LOAD_WIN - 1)) begin
              st_q   <= ST_PROG;
              pcnt_q <= '0;
              tog_o  <= 1'b0;
            end else begin
              tmr_q <= tmr_q + LW'(1);
            end
          end
        end
        ST_PROG: begin
          if (rd_end_i) tog_o <= !tog_o;
          if (prog_end_o) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end else begin
            pcnt_q <= pcnt_q + PW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_pgm_ctrl.sv
module eeprom_pgm_ctrl #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 6,
  parameter int MEM_AW     = 10,
  parameter int LOAD_WIN   = 25000,
  parameter int PROG_CYC   = 1250000,
  parameter int MIN_WE_LOW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int PAGE_D = 1 << PAGE_W;
  localparam int MEM_D  = 1 << MEM_AW;
  localparam int PG_W   = ADDR_W - PAGE_W;

  logic              wr_act, commit, rd_act, rd_end;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  logic              load_ok, prog_end, last_msb, tog;
  logic [PG_W-1:0]   page_q;
  logic [DATA_W-1:0] pbuf [PAGE_D];
  logic              pvld [PAGE_D];
  logic [MEM_AW-1:0] wa   [PAGE_D];
  logic [DATA_W-1:0] mem  [MEM_D];
  logic [DATA_W-1:0] rd_word;

  eep_strobe #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_WE_LOW(MIN_WE_LOW)
  ) u_strobe (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .wr_act_o(wr_act), .commit_o(commit), .addr_o(ld_addr), .data_o(ld_data),
    .rd_act_o(rd_act), .rd_end_o(rd_end)
  );

  eep_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
    .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk_i, .rst_ni,
    .commit_i(commit), .wr_act_i(wr_act), .addr_i(ld_addr),
    .msb_i(ld_data[DATA_W-1]), .rd_end_i(rd_end),
    .load_ok_o(load_ok), .prog_end_o(prog_end), .page_o(page_q),
    .last_msb_o(last_msb), .tog_o(tog), .busy_o, .done_o
  );

  eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pbuf (
    .clk_i, .rst_ni,
    .wr_i(load_ok), .idx_i(ld_addr[PAGE_W-1:0]), .data_i(ld_data),
    .clr_i(prog_end), .byte_o(pbuf), .vld_o(pvld)
  );

  for (genvar g = 0; g < PAGE_D; g++) begin : g_wa
    logic [ADDR_W-1:0] full;
    assign full  = {page_q, PAGE_W'(g)};
    assign wa[g] = full[MEM_AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < MEM_D; j++) mem[j] <= '0;
    end else if (prog_end) begin
      for (int i = 0; i < PAGE_D; i++) if (pvld[i]) mem[wa[i]] <= pbuf[i];
    end
  end

  assign rd_word   = mem[addr_i[MEM_AW-1:0]];
  assign data_oe_o = rd_act;

  always_comb begin
    if (!rd_act)     data_o = '0;
    else if (busy_o) data_o = {!last_msb, tog, rd_word[DATA_W-3:0]};
    else             data_o = rd_word;
  end
endmodule

// File: rtl/eeprom_pgm_ctrl_chk.sv
module eeprom_pgm_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              commit,
  input logic              load_ok,
  input logic              last_msb,
  input logic              rd_end,
  input logic              tog
);
  p_hiz_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);

  p_oe_blocks_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> !commit);

  p_no_load_in_prog_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_ok);

  p_done_after_prog_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_poll_msb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && data_oe_o) |-> data_o[DATA_W-1] == !last_msb);

  p_toggle_flip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $past(rd_end)) |-> tog != $past(tog));
endmodule

bind eeprom_pgm_ctrl eeprom_pgm_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_ni(oe_ni), .data_o(data_o),
  .data_oe_o(data_oe_o), .busy_o(busy_o), .done_o(done_o),
  .commit(commit), .load_ok(load_ok), .last_msb(last_msb),
  .rd_end(rd_end), .tog(tog)
);

// File: tb/eeprom_pgm_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_pgm_ctrl_bench;
  localparam int LW = 32;
  localparam int PC = 200;
  localparam int ML = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe, busy, done;

  always #2 clk = !clk;

  eeprom_pgm_ctrl #(
    .LOAD_WIN(LW), .PROG_CYC(PC), .MIN_WE_LOW(ML)
  ) u_eeprom_pgm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .busy_o(busy), .done_o(done)
  );

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } rd_item_t;

  rd_item_t sb_q[$];
  logic     mon_go = 1'b0;
  int checks = 0, errors = 0, done_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && done) done_cnt++;

  // monitor: pops one expected item for each sampled read
  always @(negedge clk) begin
    if (mon_go) begin
      rd_item_t it;
      it = sb_q.pop_front();
      check(doe == 1'b1, {it.tag, " bus driven"}, doe, 1);
      check((dout & it.mask) == (it.exp & it.mask), it.tag, dout & it.mask, it.exp & it.mask);
    end
  end

  task automatic rd(input logic [12:0] a, input logic [7:0] exp, input logic [7:0] mask,
                    input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    it.exp = exp; it.mask = mask; it.tag = tag;
    sb_q.push_back(it);
    mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input int n);
    @(posedge clk); #1;
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (n) @(posedge clk);
    #1; we_n = 1'b1; ce_n = 1'b1;
  endtask

  // address and data change mid-cycle (R2)
  task automatic wr_move(input logic [12:0] a0, input logic [12:0] a1,
                         input logic [7:0] d0, input logic [7:0] d1, input int n);
    @(posedge clk); #1;
    addr = a0; din = d0; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(posedge clk); #1;
    addr = a1; din = d1;
    repeat (n - 1) @(posedge clk);
    #1; we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wr_oe_low(input logic [12:0] a, input logic [7:0] d, input int n);
    @(posedge clk); #1;
    addr = a; din = d; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    repeat (n) @(posedge clk);
    #1; we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr_abort(input logic [12:0] a, input logic [7:0] d, input int n);
    @(posedge clk); #1;
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (n) @(posedge clk);
    #1; oe_n = 1'b0;
    @(posedge clk); #1;
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_busy(input string tag);
    int k = 0;
    @(negedge clk);
    while (!busy && k < 2 * LW + 60) begin @(negedge clk); k++; end
    check(busy == 1'b1, {tag, " programming started"}, busy, 1);
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    @(negedge clk);
    while (busy && k < PC + 60) begin @(negedge clk); k++; end
    check(busy == 1'b0, {tag, " programming ended"}, busy, 0);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    check(!seen, tag, seen, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp_done;
    int len;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(doe == 1'b0 && dout == 8'h00, "R9 reset bus idle", {doe, dout}, 0);
    check(busy == 1'b0 && done == 1'b0, "R6 reset flags", {busy, done}, 0);
    rd(13'h0040, 8'h00, 8'hFF, "R9 array cleared");
    @(negedge clk);
    check(doe == 1'b0 && dout == 8'h00, "R9 bus released", {doe, dout}, 0);

    // Single byte with status polling during programming
    wr(13'h0040, 8'h5A, 3);
    wait_busy("R5 single byte");
    rd(13'h0040, 8'h80, 8'hC0, "R7 R8 first poll");
    rd(13'h0040, 8'hC0, 8'hC0, "R8 second poll flips");
    rd(13'h0040, 8'h80, 8'hC0, "R8 third poll flips back");
    wr(13'h0200, 8'h3C, 3);  // R10 ignored while busy
    wait_idle("R6 single byte");
    quiet(LW + 5, "R10 write during programming opens no page");
    rd(13'h0040, 8'h5A, 8'hFF, "R7 true data after programming");
    rd(13'h0200, 8'h00, 8'hFF, "R10 write during programming not stored");
    check(done_cnt == 1, "R6 done pulses", done_cnt, 1);

    // Page with a foreign-page load and an overwritten byte
    wr(13'h0080, 8'h11, 3);
    wr(13'h00C5, 8'h99, 3);
    wr(13'h0081, 8'h22, 3);
    wr(13'h0082, 8'h33, 4);
    wr(13'h0081, 8'h77, 3);
    wr(13'h0083, 8'hC4, 5);
    wait_busy("R5 page");
    rd(13'h0083, 8'h00, 8'hC0, "R7 inverted msb of last byte");
    len = 1;
    while (busy && len < PC + 60) begin @(negedge clk); len++; end
    check(done == 1'b1, "R6 done after busy falls", done, 1);
    rd(13'h0080, 8'h11, 8'hFF, "R4 page byte 0");
    rd(13'h0081, 8'h77, 8'hFF, "R11 later load wins");
    rd(13'h0082, 8'h33, 8'hFF, "R4 page byte 2");
    rd(13'h0083, 8'hC4, 8'hFF, "R6 page byte 3");
    rd(13'h00C5, 8'h00, 8'hFF, "R4 foreign page load ignored");

    // Exact window timing and programming length
    wr(13'h0100, 8'h01, 3);
    repeat (LW) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R5 not busy before window end", busy, 0);
    @(posedge clk); @(negedge clk);
    check(busy == 1'b1, "R5 busy at window end", busy, 1);
    len = 0;
    while (busy && len < PC + 60) begin len++; @(negedge clk); end
    check(len == PC, "R6 programming length", len, PC);
    check(done == 1'b1, "R6 done pulse timing", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R6 done lasts one cycle", done, 0);

    // Restart by same-page load
    wr(13'h0110, 8'h02, 3);
    repeat (LW - 8) @(posedge clk);
    wr(13'h0111, 8'h03, 3);
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R5 window restarted by later load", busy, 0);
    repeat (LW) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R5 busy after restarted window", busy, 1);
    wait_idle("R5 restart");

    // Foreign-page load does not restart the window
    wr(13'h0140, 8'h04, 3);
    repeat (LW - 12) @(posedge clk);
    wr(13'h0180, 8'h05, 3);
    repeat (16) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R4 foreign load keeps window", busy, 1);
    wait_idle("R4 foreign");
    rd(13'h0180, 8'h00, 8'hFF, "R4 foreign byte absent");
    rd(13'h0140, 8'h04, 8'hFF, "R4 own byte written");

    // Short pulse, read strobe low, aborted cycle
    wr(13'h0010, 8'hEE, ML - 1);
    quiet(LW + 5, "R3 short pulse starts nothing");
    rd(13'h0010, 8'h00, 8'hFF, "R3 short pulse not stored");
    wr_oe_low(13'h0011, 8'hAB, 4);
    quiet(LW + 5, "R1 oe low blocks write");
    wr_abort(13'h0012, 8'hCD, 4);
    quiet(LW + 5, "R1 oe drop aborts write");
    rd(13'h0011, 8'h00, 8'hFF, "R1 oe low not stored");
    rd(13'h0012, 8'h00, 8'hFF, "R1 aborted not stored");

    // Address at open, data at close
    wr_move(13'h0300, 13'h0301, 8'h12, 8'h34, 4);
    wait_busy("R2 capture");
    wait_idle("R2 capture");
    rd(13'h0300, 8'h34, 8'hFF, "R2 opening address with closing data");
    rd(13'h0301, 8'h00, 8'hFF, "R2 moved address untouched");

    exp_done = 6;
    check(done_cnt == exp_done, "R6 total done pulses", done_cnt, exp_done);
    check(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule